// File: doc/BRIEF.md
# Preemption Comparator with Priority Stack

This block keeps the priority level at which the processor is currently running and compares it with the highest pending priority that an upstream resolver presents. When the pending level is strictly above the running level, the block raises its interrupt request. When the processor accepts the request, the running level is saved on an internal last-in-first-out stack and the pending level takes its place. An end-of-interrupt strobe restores the saved level. Software therefore never has to save or restore the running level around a nested handler.

An acknowledge can come from one of two sources. In software vector mode it is a strobe that marks a read of the acknowledge register. In hardware vector mode it is the processor's acknowledge line. The vector of the preempting request is held for the acknowledge register, and in hardware vector mode it is also driven to the processor. Software may also write the running level directly. Lowering the level that way can expose a request that was already pending.

Top module: `prio_preempt`

## Requirements
- R1: `irq_o` is high in the same cycle exactly when `pend_prio_i` is strictly greater than `cur_prio_o`. It is combinational from the input and the registered level.
- R2: A pending priority of 0 never raises `irq_o`.
- R3: The acknowledge strobe is `hw_ack_i` when `hw_mode_i`=1 and `sw_ack_i` when `hw_mode_i`=0. The strobe of the other mode is ignored. An acknowledge taken while `irq_o`=1 pushes the old `cur_prio_o` and loads `pend_prio_i` into `cur_prio_o` on the next cycle. An acknowledge while `irq_o`=0 is ignored.
- R4: `eoi_i` pops the top stack entry into `cur_prio_o` on the next cycle.
- R5: The stack holds 15 levels and returns them in last-in-first-out order.
- R6: `eoi_i` on an empty stack leaves `cur_prio_o` unchanged and sets `stack_err_o`.
- R7: An acknowledge with 15 levels stored drops the push, still loads the pending level, and sets `stack_err_o`. `stack_err_o` stays high until reset.
- R8: `cur_wr_i` loads `cur_wdata_i` into `cur_prio_o` on the next cycle. Lowering the level this way raises `irq_o` if a higher level is pending.
- R9: `ack_vec_o` captures `pend_vec_i` at every clock edge where `irq_o`=1 and holds otherwise. `hw_vec_o` equals `ack_vec_o` when `hw_mode_i`=1 and is 0 otherwise.
- R10: When several of these fall in one cycle, the order of precedence is an effective acknowledge, then `eoi_i`, then `cur_wr_i`. The losing strobes are dropped.
- R11: After reset, `cur_prio_o`=0, the stack is empty, `stack_err_o`=0 and `ack_vec_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_prio_i | input | 4 | Highest pending priority from the resolver |
| pend_vec_i | input | 9 | Vector of that pending request |
| hw_mode_i | input | 1 | 1 = hardware vector mode, 0 = software vector mode |
| sw_ack_i | input | 1 | Acknowledge-register read strobe |
| hw_ack_i | input | 1 | Processor acknowledge line |
| eoi_i | input | 1 | End-of-interrupt write strobe |
| cur_wr_i | input | 1 | Direct write of the running level |
| cur_wdata_i | input | 4 | Data for that write |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_vec_o | output | 9 | Latched vector for the acknowledge register |
| hw_vec_o | output | 9 | Vector to the processor in hardware vector mode |
| cur_prio_o | output | 4 | Running priority level |
| stack_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The acknowledge push and the end-of-interrupt pop can meet in one clock. The bench raises both strobes together while a request is pending, in directed cases and through random traffic. The expected result is that the running level takes the pending value and the stack depth grows by one. The bench judges this by draining the stack afterwards with end-of-interrupt strobes and comparing each restored level, and the point where underflow flags, against its own model.

// File: rtl/prio_preempt_pkg.sv
package prio_preempt_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ACK   = 2'd1,
    OP_EOI   = 2'd2,
    OP_WRITE = 2'd3
  } cur_op_e;

  // strict comparison: equal levels never preempt
  function automatic logic preempts(input logic [31:0] pend, input logic [31:0] cur);
    return pend > cur;
  endfunction

  // precedence among same-cycle updates of the running level
  function automatic cur_op_e pick_op(input logic ack, input logic eoi, input logic wr);
    if (ack)      return OP_ACK;
    else if (eoi) return OP_EOI;
    else if (wr)  return OP_WRITE;
    return OP_NONE;
  endfunction

  function automatic logic mode_ack(input logic hw_mode, input logic sw_ack, input logic hw_ack);
    return hw_mode ? hw_ack : sw_ack;
  endfunction

endpackage

// File: rtl/prio_cmp.sv
module prio_cmp
  import prio_preempt_pkg::*;
#(
  parameter int unsigned PRIO_W = 4
) (
  input  logic [PRIO_W-1:0] pend_i,
  input  logic [PRIO_W-1:0] cur_i,
  output logic              preempt_o
);
  always_comb preempt_o = preempts(32'(pend_i), 32'(cur_i));

  always_comb begin
    if (pend_i == '0) a_r2_zero_never: assert (!preempt_o);
  end
endmodule

// File: rtl/prio_lifo.sv
module prio_lifo #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] top_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             udf_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign ovf_o   = push_i && full_o;
  assign udf_o   = pop_i && empty_o;
  assign top_o   = empty_o ? '0 : mem[IDX_W'(cnt_q - 1'b1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (push_ok) cnt_q <= cnt_q + 1'b1;
    else if (pop_ok)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[IDX_W'(cnt_q)] <= din_i;
  end

  a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r7_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> full_o);
  a_r6_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_o && !push_i) |=> empty_o);
  a_r5_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));
endmodule

// File: rtl/vec_hold.sv
module vec_hold #(
  parameter int unsigned VEC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             hw_mode_i,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic [VEC_W-1:0] hw_vec_o
);
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vec_q <= '0;
    else if (cap_i) vec_q <= vec_i;
  end

  assign ack_vec_o = vec_q;
  assign hw_vec_o  = hw_mode_i ? vec_q : '0;

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(ack_vec_o));
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> ack_vec_o == $past(vec_i));
endmodule

// File: rtl/prio_preempt.sv
module prio_preempt
  import prio_preempt_pkg::*;
#(
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned VEC_W  = 9,
  parameter int unsigned DEPTH  = (1 << PRIO_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic [VEC_W-1:0]  pend_vec_i,
  input  logic              hw_mode_i,
  input  logic              sw_ack_i,
  input  logic              hw_ack_i,
  input  logic              eoi_i,
  input  logic              cur_wr_i,
  input  logic [PRIO_W-1:0] cur_wdata_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  output logic [VEC_W-1:0]  hw_vec_o,
  output logic [PRIO_W-1:0] cur_prio_o,
  output logic              stack_err_o
);
  logic [PRIO_W-1:0] cur_q;
  logic [PRIO_W-1:0] stk_top;
  logic              stk_empty, stk_full, stk_ovf, stk_udf;
  logic              ack_sel, ack_ev, push_ev, pop_ev;
  logic              err_q;
  cur_op_e           op;

  prio_cmp #(.PRIO_W(PRIO_W)) u_cmp (
    .pend_i   (pend_prio_i),
    .cur_i    (cur_q),
    .preempt_o(irq_o)
  );

  assign ack_sel = mode_ack(hw_mode_i, sw_ack_i, hw_ack_i);
  assign ack_ev  = ack_sel && irq_o;
  assign op      = pick_op(ack_ev, eoi_i, cur_wr_i);
  assign push_ev = (op == OP_ACK);
  assign pop_ev  = (op == OP_EOI);

  prio_lifo #(.WIDTH(PRIO_W), .DEPTH(DEPTH)) u_lifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push_ev),
    .pop_i  (pop_ev),
    .din_i  (cur_q),
    .top_o  (stk_top),
    .empty_o(stk_empty),
    .full_o (stk_full),
    .ovf_o  (stk_ovf),
    .udf_o  (stk_udf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else begin
      unique case (op)
        OP_ACK:   cur_q <= pend_prio_i;
        OP_EOI:   if (!stk_empty) cur_q <= stk_top;
        OP_WRITE: cur_q <= cur_wdata_i;
        default:  cur_q <= cur_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | stk_ovf | stk_udf;
  end

  vec_hold #(.VEC_W(VEC_W)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_i    (irq_o),
    .vec_i    (pend_vec_i),
    .hw_mode_i(hw_mode_i),
    .ack_vec_o(ack_vec_o),
    .hw_vec_o (hw_vec_o)
  );

  assign cur_prio_o  = cur_q;
  assign stack_err_o = err_q;

  a_r3_ack_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ev |=> cur_prio_o == $past(pend_prio_i));
  a_r4_eoi_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && !stk_empty) |=> cur_prio_o == $past(stk_top));
  a_r6_empty_pop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && stk_empty) |=> ($stable(cur_prio_o) && stack_err_o));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err_o |=> stack_err_o);
  a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr_i && !ack_ev && !eoi_i) |=> cur_prio_o == $past(cur_wdata_i));
  a_r10_ack_beats_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && eoi_i) |-> (push_ev && !pop_ev));
  a_r3_no_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !eoi_i && !cur_wr_i) |=> $stable(cur_prio_o));
endmodule

// File: tb/prio_preempt_tb.sv
`timescale 1ns/1ps
module prio_preempt_tb;
  localparam int PW = 4;
  localparam int VW = 9;
  localparam int DEP = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] pend_prio = '0;
  logic [VW-1:0] pend_vec = '0;
  logic hw_mode = 1'b0, sw_ack = 1'b0, hw_ack = 1'b0, eoi = 1'b0, cur_wr = 1'b0;
  logic [PW-1:0] cur_wdata = '0;
  logic irq;
  logic [VW-1:0] ack_vec, hw_vec;
  logic [PW-1:0] cur_prio;
  logic stack_err;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;

  int m_cur, m_cnt, m_vec;
  bit m_err;
  int m_stk [DEP];

  always #2.5 clk = ~clk;

  prio_preempt u_dut (
    .clk(clk), .rst_n(rst_n), .pend_prio_i(pend_prio), .pend_vec_i(pend_vec),
    .hw_mode_i(hw_mode), .sw_ack_i(sw_ack), .hw_ack_i(hw_ack), .eoi_i(eoi),
    .cur_wr_i(cur_wr), .cur_wdata_i(cur_wdata), .irq_o(irq), .ack_vec_o(ack_vec),
    .hw_vec_o(hw_vec), .cur_prio_o(cur_prio), .stack_err_o(stack_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp=<done>", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic bit exp_irq(int p, int c);
    return p > c;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {sw_ack, hw_ack, eoi, cur_wr} = '0;
    pend_prio = '0;
    pend_vec = '0;
    m_cur = 0; m_cnt = 0; m_vec = 0; m_err = 0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 cur", int'(cur_prio), 0);
    chk("R11 err", int'(stack_err), 0);
    chk("R11 vec", int'(ack_vec), 0);
  endtask

  task automatic step(input int p, input int v, input bit hm, input bit sa, input bit ha,
                      input bit eo, input bit wr, input int wd);
    bit irq_e, ack_e;
    @(negedge clk);
    pend_prio = PW'(p); pend_vec = VW'(v); hw_mode = hm;
    sw_ack = sa; hw_ack = ha; eoi = eo; cur_wr = wr; cur_wdata = PW'(wd);
    #1;
    irq_e = exp_irq(p, m_cur);
    chk(p == 0 ? "R2 irq" : "R1 irq", int'(irq), int'(irq_e));
    ack_e = (hm ? ha : sa) && irq_e;
    if (irq_e) m_vec = v;
    if (ack_e) begin
      if (m_cnt == DEP) m_err = 1;
      else begin m_stk[m_cnt] = m_cur; m_cnt++; end
      m_cur = p;
    end else if (eo) begin
      if (m_cnt == 0) m_err = 1;
      else begin m_cnt--; m_cur = m_stk[m_cnt]; end
    end else if (wr) m_cur = wd;
    @(posedge clk);
    #1;
    chk("R3/R4/R8/R10 cur", int'(cur_prio), m_cur);
    chk("R6/R7 err", int'(stack_err), int'(m_err));
    chk("R9 ackvec", int'(ack_vec), m_vec);
    chk("R9 hwvec", int'(hw_vec), hm ? m_vec : 0);
  endtask

  initial begin
    void'($urandom(32'h1d5a));
    do_reset();
    // R8 / R1: equal level does not preempt, one above does
    step(0, 0, 0, 0, 0, 0, 1, 7);
    step(7, 3, 0, 0, 0, 0, 0, 0);
    step(8, 4, 0, 0, 0, 0, 0, 0);
    // R8: lowering the level exposes a pending request
    step(6, 5, 0, 0, 0, 0, 1, 2);
    step(6, 5, 0, 0, 0, 0, 0, 0);
    // R2: zero pending at level zero
    step(0, 9, 0, 0, 0, 0, 1, 0);
    step(0, 9, 0, 0, 0, 0, 0, 0);
    // R3: wrong-mode strobe ignored, then sw ack
    step(5, 26, 0, 0, 1, 0, 0, 0);
    step(5, 26, 0, 1, 0, 0, 0, 0);
    // R3: ack without request ignored
    step(3, 11, 0, 1, 0, 0, 0, 0);
    // R3: hw mode ack, sw strobe ignored
    step(9, 300, 1, 1, 0, 0, 0, 0);
    step(9, 300, 1, 0, 1, 0, 0, 0);
    // R10: ack and eoi together, ack wins
    step(12, 77, 1, 0, 1, 1, 1, 1);
    // R4 / R5: pop back in order, then R6 underflow
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, 0, 0);
    // R10: eoi beats software write
    do_reset();
    step(4, 1, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 9);
    // R7: fill past 15 via writes lowering the level
    do_reset();
    for (int i = 0; i < DEP + 1; i++) begin
      step(0, 0, 0, 0, 0, 0, 1, i % 3);
      step((i % 12) + 3, i, i % 2, ~(i % 2), i % 2, 0, 0, 0);
    end
    // R5: drain all 15 and underflow once more
    for (int i = 0; i < DEP + 2; i++) step(0, 0, 0, 0, 0, 1, 0, 0);
    // random traffic
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      int p, r;
      p = ($urandom % 4 == 0) ? 0 : int'($urandom % 16);
      r = int'($urandom % 100);
      step(p, int'($urandom % 512), ($urandom % 2) == 1, r < 35, (r % 3) == 0,
           ($urandom % 4) == 0, ($urandom % 8) == 0, int'($urandom % 16));
      if (k % 1000 == 999) do_reset();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule